// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a 512-byte serial memory that answers on a two-wire bus. It runs on a system clock much faster than the bus clock. It takes already synchronised clock and data lines and finds the bus start and stop events in them. It accepts a select byte, loads a word address and carries out single-byte and page writes. It serves current-address, random and sequential reads. Bytes read from the array come from a synchronous read port. Each byte written is handed to a separate write controller as a single-cycle request that carries the address and the data.

The select byte is sent most significant bit first. Bits 7..4 hold the fixed device type `1010`. Bits 3..2 must equal the two board-strap inputs, with bit 3 matched against `dev_pins_i[1]`. Bit 1 chooses one of two 256-byte halves of the array, and bit 0 gives the direction (1 = read, 0 = write). One address counter serves both reads and writes. Writes advance it only inside a 16-byte page. Reads advance it across the whole array.

Top module: `ee2w_slave`

## Requirements
- R1: Until a START (data falling while the clock is high) has been seen, bus activity draws no acknowledge and causes no write request.
- R2: A select byte with bits 7..4 = 1010 and bits 3..2 equal to `dev_pins_i` is acknowledged: the data line is pulled low during the ninth clock. Any other select byte is not acknowledged, and later bytes are also ignored until the next START.
- R3: In a write, the byte after the select byte is the word address. The write address is {select bit 1, word address byte}.
- R4: Every data byte in a write is acknowledged. It produces one single-cycle `wr_req_o` with `wr_addr_o` set to the current counter and `wr_data_o` set to the byte.
- R5: After each written byte, the counter increments its low 4 bits only, wrapping within the 16-byte page. The upper 5 bits are kept.
- R6: A read select byte that does not follow a word address returns the byte at the counter, which holds the last accessed address plus one. Select bit 1 does not change the counter.
- R7: A random read is a write select byte, then a word address, then a repeated START and a read select byte. It returns the byte at the loaded address.
- R8: When the master acknowledges (data low in the ninth clock), the next byte follows. The address advances over all 9 bits and wraps from 511 to 0.
- R9: When the master does not acknowledge, the slave sends nothing more and keeps the data line released until the next START.
- R10: A START in any state ends the current transfer without any write and restarts select-byte reception.
- R11: The slave begins pulling the data line low only while the clock is low, after a clock falling edge.
- R12: After reset, and after a STOP (data rising while the clock is high), the data line is released and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired level) |
| dev_pins_i | input | 2 | Board-strap device address bits |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |
| mem_raddr_o | output | 9 | Array read address; data is expected one cycle later |
| mem_rdata_i | input | 8 | Array read data |
| wr_req_o | output | 1 | Single-cycle write request to the write controller |
| wr_addr_o | output | 9 | Address of the write request |
| wr_data_o | output | 8 | Data of the write request |

## Verification
The bench uses page writes that cross the end of a page, and a failing design would either carry into bit 4 or fail to wrap to the page start. A sequential read crosses address 511, where a counter limited to 8 bits, or one that wrapped like a write, would return the wrong byte. Other tests cover a START in the middle of a data byte, a select byte with the wrong strap bits, traffic that arrives before any START, and a byte clocked after a master NACK. A design that got these wrong would issue a spurious write, acknowledge a foreign address, or drive the line when it should not.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_TX_END,
    ST_MACK,
    ST_MACK_END
  } ee2w_state_t;

  typedef enum logic [1:0] {
    K_SEL,
    K_WADDR,
    K_DATA
  } ee2w_kind_t;

  // select byte: [7:4] device type, [3:2] strap bits, [1] half, [0] direction
  function automatic logic sel_match(input logic [7:0] b,
                                     input logic [3:0] dev_type,
                                     input logic [1:0] pins);
    return (b[7:4] == dev_type) && (b[3:2] == pins);
  endfunction

endpackage

// File: rtl/ee2w_bus_events.sv
module ee2w_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i && !scl_q;
  assign scl_fall_o = !scl_i && scl_q;
  assign start_o    = scl_i && scl_q && sda_q && !sda_i;
  assign stop_o     = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/ee2w_addr_ctr.sv
module ee2w_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_full_i,
  input  logic              inc_page_i,
  output logic [ADDR_W-1:0] addr_o
);
  function automatic logic [ADDR_W-1:0] step_full(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] step_page(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
    end else if (load_i) begin
      addr_o <= load_val_i;
    end else if (inc_full_i) begin
      addr_o <= step_full(addr_o);
    end else if (inc_page_i) begin
      addr_o <= step_page(addr_o);
    end
  end
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int         MEM_BYTES  = 512,
  parameter int         PAGE_BYTES = 16,
  parameter logic [3:0] DEV_TYPE   = 4'b1010,
  localparam int        ADDR_W     = $clog2(MEM_BYTES),
  localparam int        PAGE_W     = $clog2(PAGE_BYTES),
  localparam int        WORD_W     = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        dev_pins_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  // bus events, brought out by name for the checker
  logic scl_rise;
  logic scl_fall;
  logic start_evt;
  logic stop_evt;

  ee2w_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  ee2w_state_t       state;
  ee2w_kind_t        kind;
  logic [2:0]        bitcnt;
  logic [7:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic              is_read;
  logic              pblk;
  logic [ADDR_W-1:0] cur_addr;

  // named internal events
  logic rx_byte_end;
  logic sel_ok;
  logic tx_load;
  logic ctr_load;
  logic ctr_inc_full;
  logic ctr_inc_page;

  assign rx_byte_end  = (state == ST_RX_END) && scl_fall;
  assign sel_ok       = sel_match(rx_sh, DEV_TYPE, dev_pins_i);
  assign tx_load      = scl_fall &&
                        (((state == ST_ACK) && (kind == K_SEL) && is_read) ||
                         (state == ST_MACK_END));
  assign ctr_load     = rx_byte_end && (kind == K_WADDR);
  assign ctr_inc_page = rx_byte_end && (kind == K_DATA);
  assign ctr_inc_full = tx_load;

  ee2w_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ctr_load),
    .load_val_i ({pblk, rx_sh[WORD_W-1:0]}),
    .inc_full_i (ctr_inc_full),
    .inc_page_i (ctr_inc_page),
    .addr_o     (cur_addr)
  );

  assign mem_raddr_o = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= K_SEL;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      is_read    <= 1'b0;
      pblk       <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_req_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_req_o <= 1'b0;
      if (start_evt) begin
        state      <= ST_RX;
        kind       <= K_SEL;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_evt) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
          end
          ST_RX: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[6:0], sda_i};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) state <= ST_RX_END;
            end
          end
          ST_RX_END: begin
            if (scl_fall) begin
              unique case (kind)
                K_SEL: begin
                  if (sel_ok) begin
                    is_read    <= rx_sh[0];
                    pblk       <= rx_sh[1];
                    sda_pull_o <= 1'b1;
                    state      <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_WADDR: begin
                  sda_pull_o <= 1'b1;
                  state      <= ST_ACK;
                end
                default: begin
                  sda_pull_o <= 1'b1;
                  wr_req_o   <= 1'b1;
                  wr_addr_o  <= cur_addr;
                  wr_data_o  <= rx_sh;
                  state      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if ((kind == K_SEL) && is_read) begin
                tx_sh      <= mem_rdata_i;
                sda_pull_o <= ~mem_rdata_i[7];
                state      <= ST_TX;
              end else begin
                sda_pull_o <= 1'b0;
                kind       <= (kind == K_SEL) ? K_WADDR : K_DATA;
                state      <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) state <= ST_TX_END;
            end else if (scl_fall) begin
              tx_sh      <= {tx_sh[6:0], 1'b0};
              sda_pull_o <= ~tx_sh[6];
            end
          end
          ST_TX_END: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              state      <= ST_MACK;
            end
          end
          ST_MACK: begin
            if (scl_rise) state <= sda_i ? ST_IDLE : ST_MACK_END;
          end
          default: begin
            if (scl_fall) begin
              bitcnt     <= '0;
              tx_sh      <= mem_rdata_i;
              sda_pull_o <= ~mem_rdata_i[7];
              state      <= ST_TX;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_pull_o,
  input logic wr_req_o
);
  // R11
  pull_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_evt || stop_evt));

  // R11
  pull_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull_o);

  // R4
  write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> sda_pull_o);

  // R4
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o);
endmodule

bind ee2w_slave ee2w_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .scl_fall   (scl_fall),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .sda_pull_o (sda_pull_o),
  .wr_req_o   (wr_req_o)
);

// File: tb/ee2w_slave_bench.sv
module ee2w_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] PINS = 2'b10;
  localparam logic [7:0] SEL_W0 = 8'hA8;
  localparam logic [7:0] SEL_W1 = 8'hAA;
  localparam logic [7:0] SEL_RD = 8'hA9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       pull;
  logic [8:0] raddr;
  logic [7:0] rdata;
  logic       wr_req;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  wire        sda_line = sda_m & ~pull;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int bad_drive = 0;
  logic pull_q = 1'b0;
  logic [8:0] wr_log_a [16];
  logic [7:0] wr_log_d [16];
  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  ee2w_slave u_ee2w_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .dev_pins_i  (PINS),
    .sda_pull_o  (pull),
    .mem_raddr_o (raddr),
    .mem_rdata_i (rdata),
    .wr_req_o    (wr_req),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // array and write controller model
  always @(posedge clk) begin
    rdata <= mem[raddr];
    if (wr_req) begin
      mem[wr_addr] <= wr_data;
      wr_log_a[wr_cnt % 16] <= wr_addr;
      wr_log_d[wr_cnt % 16] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (pull && !pull_q && scl_m) bad_drive <= bad_drive + 1;
    pull_q <= pull;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(4);
    scl_m = 1'b1; hold(4);
    sda_m = 1'b0; hold(4);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(4);
    scl_m = 1'b1; hold(4);
    sda_m = 1'b1; hold(4);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    hold(4);
    scl_m = 1'b1; hold(8);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(4);
    scl_m = 1'b1; hold(4);
    ack = sda_line; hold(4);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hold(4);
      scl_m = 1'b1; hold(4);
      b = {b[6:0], sda_line}; hold(4);
      scl_m = 1'b0;
    end
    hold(2); sda_m = mack; hold(2);
    scl_m = 1'b1; hold(8);
    scl_m = 1'b0; hold(4);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R12 reset pull", int'(pull), 0);
    chk("R12 reset wr_req", int'(wr_req), 0);
  endtask

  task automatic t_no_start();
    logic a;
    int n0 = wr_cnt;
    scl_m = 1'b0; hold(4);
    send_byte(SEL_W0, a);
    chk("R1 no ack before start", int'(a), 1);
    send_byte(8'h12, a);
    chk("R1 no ack second byte", int'(a), 1);
    chk("R1 no write", wr_cnt, n0);
    sda_m = 1'b1; hold(2); scl_m = 1'b1; hold(4);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'hA0, a);
    chk("R2 foreign select nack", int'(a), 1);
    send_byte(8'h00, a);
    chk("R2 stays idle", int'(a), 1);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(SEL_W1, a);
    chk("R2 select ack", int'(a), 0);
    send_byte(8'h35, a);
    chk("R4 word address ack", int'(a), 0);
    send_byte(8'h5C, a);
    chk("R4 data ack", int'(a), 0);
    bus_stop();
    exp_mem[9'h135] = 8'h5C;
    chk("R4 one request", wr_cnt, n0 + 1);
    chk("R3 write address", int'(wr_log_a[n0 % 16]), 9'h135);
    chk("R4 write data", int'(wr_log_d[n0 % 16]), 8'h5C);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(SEL_RD, a);
    chk("R6 read select ack", int'(a), 0);
    recv_byte(1'b1, d);
    chk("R6 current address data", int'(d), int'(exp_mem[9'h136]));
    bus_stop();
  endtask

  task automatic t_page_write();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(SEL_W0, a);
    send_byte(8'h1E, a);
    send_byte(8'hC1, a);
    send_byte(8'hC2, a);
    send_byte(8'hC3, a);
    chk("R4 page byte ack", int'(a), 0);
    bus_stop();
    exp_mem[9'h01E] = 8'hC1;
    exp_mem[9'h01F] = 8'hC2;
    exp_mem[9'h010] = 8'hC3;
    chk("R5 three requests", wr_cnt, n0 + 3);
    chk("R5 second address", int'(wr_log_a[(n0 + 1) % 16]), 9'h01F);
    chk("R5 wrap address", int'(wr_log_a[(n0 + 2) % 16]), 9'h010);
  endtask

  task automatic random_read(input logic [8:0] addr, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(addr[8] ? SEL_W1 : SEL_W0, a);
    send_byte(addr[7:0], a);
    bus_start();
    send_byte(SEL_RD, a);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic t_readback();
    logic [7:0] d;
    random_read(9'h135, d);
    chk("R7 random read of written byte", int'(d), 8'h5C);
    random_read(9'h010, d);
    chk("R5 wrapped byte stored", int'(d), 8'hC3);
  endtask

  task automatic t_sequential();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(SEL_W1, a);
    send_byte(8'hFF, a);
    bus_start();
    send_byte(SEL_RD, a);
    recv_byte(1'b0, d);
    chk("R7 random read 511", int'(d), int'(exp_mem[511]));
    recv_byte(1'b0, d);
    chk("R8 rollover to 0", int'(d), int'(exp_mem[0]));
    recv_byte(1'b1, d);
    chk("R8 next address 1", int'(d), int'(exp_mem[1]));
    recv_byte(1'b1, d);
    chk("R9 released after nack", int'(d), 8'hFF);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    int n0 = wr_cnt;
    bus_start();
    send_byte(SEL_W0, a);
    send_byte(8'h40, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(SEL_RD, a);
    chk("R10 select after restart ack", int'(a), 0);
    recv_byte(1'b1, d);
    chk("R10 read at loaded address", int'(d), int'(exp_mem[9'h040]));
    bus_stop();
    chk("R10 no write on abort", wr_cnt, n0);
  endtask

  task automatic t_stop_idle();
    logic a;
    bus_start();
    send_byte(SEL_W0, a);
    bus_stop();
    chk("R12 released after stop", int'(pull), 0);
    scl_m = 1'b0; hold(4);
    send_byte(SEL_W0, a);
    chk("R12 idle after stop", int'(a), 1);
    sda_m = 1'b1; hold(2); scl_m = 1'b1; hold(4);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = pat(i);
      exp_mem[i] = pat(i);
    end
    hold(5);
    t_reset();
    rst_n = 1'b1;
    hold(5);
    t_no_start();
    t_mismatch();
    t_byte_write();
    t_current_read();
    t_page_write();
    t_readback();
    t_sequential();
    t_abort();
    t_stop_idle();
    chk("R11 no drive while clock high", bad_drive, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule